// File: doc/BRIEF.md
# Transparent Receive Synchronization Hunter

This block sits at the front of a bit-transparent serial receiver and decides the moment at which the incoming bit stream starts to count as data. Until that moment it hunts. Once it has found the start, it fixes the byte boundary there and delivers whole bytes, each marked by a single-cycle valid strobe. An in-sync flag stays high for as long as the alignment holds.

Four start methods are available, chosen by mode inputs:

- **Slot-strobe start:** in highway mode, data begins with the bit that arrives alongside a slot-start strobe.
- **Carrier-edge start:** with external sync enabled, an active-low carrier-detect input marks the start. The bit received one clock before the carrier was seen low counts as the first data bit.
- **Free pattern hunt:** the stream is compared on every edge with a programmable two-character sync word.
- **Gated pattern hunt:** the same pattern hunt, but it only counts once carrier detect has been seen low.

In both pattern hunts, the second sync character is handed on as the first data byte. A low enable or a restart pulse drops synchronization and starts a new hunt.

All activity takes place on the rising edge of the receive clock. Inputs are sampled on that edge, and outputs change right after it.

Top module: `rxSyncHunter`

## Requirements
- R1: With highway=0 and extSync=1, a hunting block enters sync on the edge where cdN is sampled low. inSync is high from that edge on. It never enters sync while cdN is sampled high.
- R2: After a carrier-edge start, the first byte consists of the following bits, in this order:
  - the bit sampled one edge before the syncing edge, which becomes bit 7;
  - the bit sampled on the syncing edge;
  - the next six sampled bits.

  rxValid is high in the cycle after the sixth of those later edges.
- R3: While inSync is high and enable=1 and restart=0, the block ignores three things: cdN, slotStart and pattern matches. inSync stays high, and the byte cadence is not disturbed.
- R4: With highway=0, extSync=0 and diagNormal=0, the block enters sync on the edge where the 16 most recent sampled bits equal syncPattern. The comparison includes the bit sampled on that edge. The oldest of these bits is compared with syncPattern[15]. After reset the bit history reads as all zeros.
- R5: With highway=0, extSync=0 and diagNormal=1, a pattern match only counts on an edge where one of two things holds:
  - cdN is sampled low on that edge; or
  - cdN was sampled low on an earlier edge of the current hunt.
- R6: On a pattern-hunt sync, rxByte equals syncPattern[7:0] with rxValid high in the cycle after the matching edge. Byte assembly then restarts with the next bit.
- R7: With highway=1, the block enters sync on the edge where slotStart is sampled high, regardless of extSync. The bit sampled on that edge is bit 7 of the first byte.
- R8: While the block is in sync, each group of 8 bits is delivered as one byte. The first bit of the group is placed in bit 7. rxValid is high for exactly one cycle per byte.
- R9: On any edge where enable=0 or restart=1, the block does the following:
  - it clears inSync;
  - it emits no byte;
  - it discards any partial byte;
  - it forgets an earlier low cdN sample;
  - it does not enter sync on that edge.
- R10: While rstN is low, inSync, rxValid and rxByte are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Receiver enable; low forces hunting |
| restart | input | 1 | Hunt restart pulse, active high |
| rxBit | input | 1 | Serial receive data |
| cdN | input | 1 | Carrier detect, active low |
| slotStart | input | 1 | Highway time-slot start strobe |
| highway | input | 1 | Selects highway slot-strobe start |
| extSync | input | 1 | Selects carrier-edge start (when not highway) |
| diagNormal | input | 1 | Gates the pattern hunt with carrier detect |
| syncPattern | input | 16 | Sync word; first character in [15:8] |
| rxByte | output | 8 | Last assembled byte |
| rxValid | output | 1 | One-cycle strobe for a new byte |
| inSync | output | 1 | High while aligned |

## Verification
The stimulus covers each of the four start methods.

- **Carrier-edge start:** random data runs under a long carrier-high stretch before carrier detect falls. This shows whether the first byte picks up the bit held back from the previous edge. Carrier detect is then toggled after sync to confirm that alignment does not move.
- **Pattern hunts:** random data precedes the sync word. In the gated hunt, the word is first sent with carrier high and then again after carrier drops, which separates the gated hunt from the free one.
- **Highway start:** a slot strobe is raised while carrier detect and stray pattern bits are present, showing that the strobe alone sets the boundary.
- **Losing sync:** restart pulses and enable-low stretches are inserted mid-byte. These show that partial bytes are dropped and that an earlier carrier sample is forgotten.

// File: rtl/rxsh_pkg.sv
package rxsh_pkg;
  typedef struct packed {
    logic clearSync;
    logic loadCd;
    logic loadSlot;
    logic loadPattern;
    logic shiftIn;
  } ctlStrobe_t;
endpackage

// File: rtl/rxshControl.sv
module rxshControl
  import rxsh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       restart,
  input  logic       cdN,
  input  logic       slotStart,
  input  logic       highway,
  input  logic       extSync,
  input  logic       diagNormal,
  input  logic       patMatch,
  output ctlStrobe_t strobe,
  output logic       inSync
);
  logic armed;
  logic halt;
  logic hunting;
  logic cdLow;
  logic gateOk;
  logic anyLoad;

  always_comb begin
    halt    = !enable || restart;
    hunting = !inSync && !halt;
    cdLow   = !cdN;
    gateOk  = !diagNormal || armed || cdLow;
    strobe.clearSync   = halt;
    strobe.loadSlot    = hunting && highway && slotStart;
    strobe.loadCd      = hunting && !highway && extSync && cdLow;
    strobe.loadPattern = hunting && !highway && !extSync && gateOk && patMatch;
    strobe.shiftIn     = inSync && !halt;
    anyLoad = strobe.loadSlot || strobe.loadCd || strobe.loadPattern;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSync <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (halt)         inSync <= 1'b0;
      else if (anyLoad) inSync <= 1'b1;

      if (halt || anyLoad)            armed <= 1'b0;
      else if (!inSync && cdLow)      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rxshDatapath.sv
module rxshDatapath
  import rxsh_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxBit,
  input  logic [SYNC_W-1:0] syncPattern,
  input  ctlStrobe_t        strobe,
  output logic              patMatch,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              prevBit;
  logic [SYNC_W-1:0] history;
  logic [BYTE_W-1:0] assemble;
  logic [CNT_W-1:0]  bitCount;
  logic [BYTE_W-1:0] nextAssemble;

  always_comb begin
    patMatch     = ({history[SYNC_W-2:0], rxBit} == syncPattern);
    nextAssemble = {assemble[BYTE_W-2:0], rxBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit  <= 1'b0;
      history  <= '0;
      assemble <= '0;
      bitCount <= '0;
      rxByte   <= '0;
      rxValid  <= 1'b0;
    end else begin
      prevBit <= rxBit;
      history <= {history[SYNC_W-2:0], rxBit};
      rxValid <= 1'b0;
      if (strobe.clearSync) begin
        bitCount <= '0;
      end else if (strobe.loadPattern) begin
        rxByte   <= syncPattern[BYTE_W-1:0];
        rxValid  <= 1'b1;
        bitCount <= '0;
      end else if (strobe.loadCd) begin
        assemble <= {{(BYTE_W-2){1'b0}}, prevBit, rxBit};
        bitCount <= CNT_W'(2);
      end else if (strobe.loadSlot) begin
        assemble <= {{(BYTE_W-1){1'b0}}, rxBit};
        bitCount <= CNT_W'(1);
      end else if (strobe.shiftIn) begin
        assemble <= nextAssemble;
        if (bitCount == LAST_BIT) begin
          rxByte   <= nextAssemble;
          rxValid  <= 1'b1;
          bitCount <= '0;
        end else begin
          bitCount <= bitCount + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rxSyncHunter.sv
module rxSyncHunter
  import rxsh_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              restart,
  input  logic              rxBit,
  input  logic              cdN,
  input  logic              slotStart,
  input  logic              highway,
  input  logic              extSync,
  input  logic              diagNormal,
  input  logic [SYNC_W-1:0] syncPattern,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              inSync
);
  ctlStrobe_t strobe;
  logic       patMatch;

  rxshControl uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .restart(restart),
    .cdN(cdN), .slotStart(slotStart), .highway(highway),
    .extSync(extSync), .diagNormal(diagNormal), .patMatch(patMatch),
    .strobe(strobe), .inSync(inSync)
  );

  rxshDatapath #(.BYTE_W(BYTE_W), .SYNC_W(SYNC_W)) uDp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .syncPattern(syncPattern),
    .strobe(strobe), .patMatch(patMatch), .rxByte(rxByte), .rxValid(rxValid)
  );
endmodule

// File: rtl/rxshChecker.sv
module rxshChecker #(
  parameter int BYTE_W = 8,
  parameter int SYNC_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              restart,
  input logic              cdN,
  input logic              highway,
  input logic              extSync,
  input logic [SYNC_W-1:0] syncPattern,
  input logic [BYTE_W-1:0] rxByte,
  input logic              rxValid,
  input logic              inSync
);
  AST_CD_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(inSync) && $past(!highway && extSync)) |-> $past(!cdN)); // R1
  AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inSync && enable && !restart) |=> inSync); // R3
  AST_PATTERN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(inSync) && rxValid) |-> (rxByte == $past(syncPattern[BYTE_W-1:0]))); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R8
  AST_VALID_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> inSync); // R8
  AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (!enable || restart) |=> (!inSync && !rxValid)); // R9
  always_comb begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!inSync && !rxValid && rxByte == '0); // R10
    end
  end
endmodule

bind rxSyncHunter rxshChecker #(.BYTE_W(BYTE_W), .SYNC_W(SYNC_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .restart(restart), .cdN(cdN),
  .highway(highway), .extSync(extSync), .syncPattern(syncPattern),
  .rxByte(rxByte), .rxValid(rxValid), .inSync(inSync)
);

// File: tb/sim_rxSyncHunter.sv
`timescale 1ns/1ps
module sim_rxSyncHunter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        restart = 1'b0;
  logic        rxBit = 1'b0;
  logic        cdN = 1'b1;
  logic        slotStart = 1'b0;
  logic        highway = 1'b0;
  logic        extSync = 1'b0;
  logic        diagNormal = 1'b0;
  logic [15:0] syncPattern = 16'hA5C3;
  logic [7:0]  rxByte;
  logic        rxValid;
  logic        inSync;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R10";

  // reference model state
  bit mSync, mArmed, mValid, mPrev;
  int mCnt, mAsm, mByte;
  bit hist[$];

  always #10 clk = ~clk;

  rxSyncHunter u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .restart(restart), .rxBit(rxBit),
    .cdN(cdN), .slotStart(slotStart), .highway(highway), .extSync(extSync),
    .diagNormal(diagNormal), .syncPattern(syncPattern),
    .rxByte(rxByte), .rxValid(rxValid), .inSync(inSync)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync = 0; mArmed = 0; mValid = 0; mPrev = 0;
      mCnt = 0; mAsm = 0; mByte = 0;
      hist.delete();
      for (int i = 0; i < 16; i++) hist.push_back(1'b0);
    end else begin
      bit halt, match, loaded;
      int win;
      hist.push_back(rxBit);
      void'(hist.pop_front());
      win = 0;
      foreach (hist[i]) win = win * 2 + hist[i];
      match = (win == syncPattern);
      halt = !enable || restart;
      mValid = 0;
      loaded = 0;
      if (halt) begin
        mSync = 0; mArmed = 0; mCnt = 0;
      end else if (!mSync) begin
        if (highway) begin
          if (slotStart) begin mAsm = rxBit; mCnt = 1; loaded = 1; end
        end else if (extSync) begin
          if (!cdN) begin mAsm = mPrev * 2 + rxBit; mCnt = 2; loaded = 1; end
        end else if ((!diagNormal || mArmed || !cdN) && match) begin
          mByte = syncPattern & 8'hFF; mValid = 1; mCnt = 0; loaded = 1;
        end
        if (loaded) begin mSync = 1; mArmed = 0; end
        else if (!cdN) mArmed = 1;
      end else begin
        mAsm = (mAsm * 2 + rxBit) & 8'hFF;
        mCnt++;
        if (mCnt == 8) begin mByte = mAsm; mValid = 1; mCnt = 0; end
      end
      mPrev = rxBit;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(curReq, inSync, mSync, "inSync");
      check(curReq, rxValid, mValid, "rxValid");
      check(curReq, rxByte, mByte, "rxByte");
    end
  end

  task automatic sendBit(bit b);
    rxBit = b;
    @(negedge clk);
  endtask

  task automatic sendRandom(int n);
    for (int i = 0; i < n; i++) sendBit(1'($urandom_range(0, 1)));
  endtask

  task automatic sendWord(logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseRestart();
    restart = 1'b1;
    sendBit(1'b1);
    restart = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R10";
    check("R10", inSync, 0, "reset inSync");
    check("R10", rxValid, 0, "reset rxValid");
    rstN = 1'b1;
    enable = 1'b1;

    // carrier-edge start with a known lead bit
    curReq = "R1"; extSync = 1'b1; cdN = 1'b1;
    sendRandom(20);
    check("R1", inSync, 0, "no sync with carrier high");
    sendBit(1'b1);
    cdN = 1'b0; curReq = "R2";
    sendBit(1'b0);
    check("R1", inSync, 1, "sync on carrier low");
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    sendBit(1'b0);
    check("R2", rxValid, 1, "first carrier byte strobe");
    check("R2", rxByte, 8'hB2, "first carrier byte");
    curReq = "R3";
    for (int i = 0; i < 30; i++) begin
      cdN = ~cdN; slotStart = (i % 5 == 0);
      sendRandom(1);
    end
    slotStart = 1'b0;
    check("R3", inSync, 1, "sync kept through toggles");

    // restart mid-byte
    curReq = "R9";
    pulseRestart();
    check("R9", inSync, 0, "restart drops sync");
    cdN = 1'b1;
    sendRandom(5);
    cdN = 1'b0; sendRandom(19);

    // free pattern hunt
    curReq = "R4"; extSync = 1'b0; diagNormal = 1'b0; cdN = 1'b1;
    pulseRestart();
    sendBit(1'b0); sendBit(1'b0);
    sendWord(16'hA5C3);
    curReq = "R6";
    check("R6", rxValid, 1, "pattern byte strobe");
    check("R6", rxByte, 8'hC3, "second sync char delivered");
    curReq = "R8";
    sendRandom(40);

    // gated pattern hunt
    curReq = "R5"; diagNormal = 1'b1; syncPattern = 16'h3C96;
    pulseRestart();
    sendWord(16'h3C96);
    check("R5", inSync, 0, "pattern ignored before carrier");
    cdN = 1'b0; sendBit(1'b1); cdN = 1'b1;
    sendWord(16'h3C96);
    check("R5", inSync, 1, "pattern after carrier seen");
    check("R5", rxByte, 8'h96, "gated pattern byte");
    sendRandom(20);
    // carrier memory forgotten on restart
    curReq = "R9";
    pulseRestart();
    sendWord(16'h3C96);
    check("R9", inSync, 0, "armed cleared by restart");

    // highway slot start
    curReq = "R7"; highway = 1'b1; extSync = 1'b1; cdN = 1'b0;
    sendRandom(8);
    check("R7", inSync, 0, "carrier ignored in highway");
    slotStart = 1'b1; sendBit(1'b1); slotStart = 1'b0;
    check("R7", inSync, 1, "slot strobe syncs");
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    sendBit(1'b0); sendBit(1'b1);
    check("R7", rxByte, 8'h9D, "slot first byte");
    curReq = "R8";
    sendRandom(35);

    // enable low
    curReq = "R9"; enable = 1'b0;
    sendRandom(6);
    check("R9", inSync, 0, "enable low holds hunt");
    enable = 1'b1; highway = 1'b0; extSync = 1'b0; diagNormal = 1'b0;
    curReq = "R4"; sendRandom(60);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule